// File: doc/BRIEF.md
# I2C SCL Phase-Split Clock Generator

This block times the SCL waveform of an I2C master from a fast peripheral clock. The low and the high half of each SCL period come from two independent divider fields. Each field is scaled by a fixed factor of eight, so the duty cycle can be asymmetric. When the total divisor is odd, software places the extra unit in the high field. The block drives a registered SCL level. It also gives the bit engine four single-cycle strobes: one at the falling edge, one at the rising edge, one at the middle of the low phase (where SDA may change) and one at the middle of the high phase (where SDA is sampled).

The bus engine starts the clock by raising `run` with `en` set. It can freeze the clock at any point by dropping `run`. The block reads the SCL line back through a synchronizer. During the high phase it waits for a slave that stretches the clock. New divider values are picked up only when a new low phase starts, so a phase is never cut short. Software computes the divider values from the target rate.

Top module: `i2c_scl_phase_gen`

## Requirements
- R1: With `run` held high, every low phase keeps `scl_out` at 0 for exactly 8 × (`div_lo` + 1) clock cycles.
- R2: With no stretching, every high phase keeps `scl_out` at 1 for exactly 8 × (`div_hi` + 1) cycles. Any pair of field values is accepted, and both fields at 0 give a 16-cycle period.
- R3: Both divider fields are captured only in the cycle that starts a low phase. A change made during a low phase affects neither that phase nor the high phase after it, and does apply to the next period.
- R4: During the high phase the counter waits while the synchronized line reads low, once SYNC_STAGES counts have passed. If the line is first captured high at the clock edge that ends high-phase cycle R (first cycle is 0, R ≥ SYNC_STAGES), the high phase lasts R + 8 × (`div_hi` + 1) cycles.
- R5: Each low phase has exactly one `fall_stb`, in its cycle 0, and exactly one `mid_lo_stb`, in its cycle 4 × (`div_lo` + 1). Each high phase has exactly one `rise_stb`, in its cycle 0, and exactly one `mid_hi_stb`, in its cycle 4 × (`div_hi` + 1). At most one strobe is high in any cycle.
- R6: While `run` is low, the counter and `scl_out` hold and no strobe is asserted. A low phase held this way for N cycles lasts 8 × (`div_lo` + 1) + N cycles.
- R7: In reset, and in the cycle after `en` is sampled low, `scl_out` is 1 and all strobes are 0. The count is cleared, so the next low phase has its full length.
- R8: From the released state, `scl_out` stays 1 while `run` is low. The first low phase starts in the cycle after `en` and `run` are both sampled high, and `fall_stb` is asserted in that first low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low releases SCL and clears the count |
| run | input | 1 | Run (1) or hold (0) request from the bus engine |
| div_lo | input | DIV_W | Low-phase divider field |
| div_hi | input | DIV_W | High-phase divider field |
| scl_in | input | 1 | Sampled SCL line level (asynchronous) |
| scl_out | output | 1 | Registered SCL drive level; 1 = released |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| mid_lo_stb | output | 1 | Middle of the low phase (SDA launch point) |
| mid_hi_stb | output | 1 | Middle of the high phase (SDA sample point) |

## Verification
The bench builds the generator with DIV_W = 4, the default scale of eight and a two-stage synchronizer. Both extremes of each field (0 and 15) can then be reached, and the longest phase lasts only 128 cycles. A 15/0 split, an odd split and the 0/0 fastest case all fit in a short run. The two-stage synchronizer fixes the stretch window at two counts. This lets the bench release a stretching slave at a known cycle and predict the exact length of the high phase.

// File: rtl/sclgen_pkg.sv
// Shared types for the SCL phase-split generator.
package sclgen_pkg;
    // Phase of the generated clock; IDLE means SCL released and not counting.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;
endpackage

// File: rtl/sclgen_sync.sv
// sclgen_sync: flop chain that brings the asynchronous SCL line into the clk domain.
// Assumes the line idles high, so the chain resets to 1.
module sclgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '1;
                else        sr <= d;
            end
        end else begin : g_chain
            // Shift the line level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '1;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/sclgen_timer.sv
// sclgen_timer: phase state, phase counter and the registered SCL level.
// The divider fields are captured when a low phase starts. In the high phase the
// counter waits for the synchronized line once the synchronizer latency has passed.
// Assumes the low/high phase minimum (2**SCALE_LOG2) exceeds SYNC_STAGES.
module sclgen_timer
    import sclgen_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SCALE_LOG2  = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = DIV_W + SCALE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [DIV_W-1:0] div_hi,
    input  logic             line_hi,
    output phase_t           phase,
    output logic [CNT_W-1:0] cnt,
    output logic [DIV_W-1:0] lo_q,
    output logic [DIV_W-1:0] hi_q,
    output logic             scl_out,
    output logic             adv
);
    logic [CNT_W-1:0] last_lo;
    logic [CNT_W-1:0] last_hi;
    logic             stall;

    // Final count of each phase: 8*(d+1)-1 is d followed by SCALE_LOG2 ones.
    assign last_lo = {lo_q, {SCALE_LOG2{1'b1}}};
    assign last_hi = {hi_q, {SCALE_LOG2{1'b1}}};

    // A slave is stretching when the line still reads low after the latency window.
    assign stall = (phase == PH_HIGH) && !line_hi && (cnt >= CNT_W'(SYNC_STAGES));
    assign adv   = en && run && !stall;

    // Phase sequencing, counting and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            scl_out <= 1'b1;
        end else if (adv) begin
            unique case (phase)
                PH_IDLE: begin
                    phase   <= PH_LOW;
                    cnt     <= '0;
                    lo_q    <= div_lo;
                    hi_q    <= div_hi;
                    scl_out <= 1'b0;
                end
                PH_LOW: begin
                    if (cnt == last_lo) begin
                        phase   <= PH_HIGH;
                        cnt     <= '0;
                        scl_out <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == last_hi) begin
                        phase   <= PH_LOW;
                        cnt     <= '0;
                        lo_q    <= div_lo;
                        hi_q    <= div_hi;
                        scl_out <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase   <= PH_IDLE;
                    cnt     <= '0;
                    scl_out <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/sclgen_strobe.sv
// sclgen_strobe: decodes the edge and midpoint strobes from phase and count.
// A strobe fires only in a cycle where the counter advances, so a held count
// never repeats it.
module sclgen_strobe
    import sclgen_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SCALE_LOG2 = 3,
    localparam int CNT_W     = DIV_W + SCALE_LOG2
) (
    input  phase_t           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DIV_W-1:0] lo_q,
    input  logic [DIV_W-1:0] hi_q,
    input  logic             adv,
    output logic             fall_stb,
    output logic             rise_stb,
    output logic             mid_lo_stb,
    output logic             mid_hi_stb
);
    logic [CNT_W-1:0] mid_lo;
    logic [CNT_W-1:0] mid_hi;

    // Midpoint is half the phase: (d+1) * 2**(SCALE_LOG2-1).
    assign mid_lo = (CNT_W'(lo_q) + CNT_W'(1)) << (SCALE_LOG2 - 1);
    assign mid_hi = (CNT_W'(hi_q) + CNT_W'(1)) << (SCALE_LOG2 - 1);

    // Strobe decode, gated by counter advance.
    always_comb begin
        fall_stb   = adv && (phase == PH_LOW)  && (cnt == '0);
        rise_stb   = adv && (phase == PH_HIGH) && (cnt == '0);
        mid_lo_stb = adv && (phase == PH_LOW)  && (cnt == mid_lo);
        mid_hi_stb = adv && (phase == PH_HIGH) && (cnt == mid_hi);
    end
endmodule

// File: rtl/i2c_scl_phase_gen.sv
// i2c_scl_phase_gen: SCL generator with separate low/high divider fields
// (phase = 2**SCALE_LOG2 * (field+1) cycles), stretch wait and bit-engine strobes.
// Assumes scl_in is the open-drain line level, which is asynchronous to clk.
module i2c_scl_phase_gen
    import sclgen_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SCALE_LOG2  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [DIV_W-1:0] div_hi,
    input  logic             scl_in,
    output logic             scl_out,
    output logic             fall_stb,
    output logic             rise_stb,
    output logic             mid_lo_stb,
    output logic             mid_hi_stb
);
    localparam int CNT_W = DIV_W + SCALE_LOG2;

    logic             line_hi;
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] lo_q;
    logic [DIV_W-1:0] hi_q;
    logic             adv;

    sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (line_hi)
    );

    sclgen_timer #(
        .DIV_W       (DIV_W),
        .SCALE_LOG2  (SCALE_LOG2),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .run     (run),
        .div_lo  (div_lo),
        .div_hi  (div_hi),
        .line_hi (line_hi),
        .phase   (phase),
        .cnt     (cnt),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .scl_out (scl_out),
        .adv     (adv)
    );

    sclgen_strobe #(
        .DIV_W      (DIV_W),
        .SCALE_LOG2 (SCALE_LOG2)
    ) u_strobe (
        .phase      (phase),
        .cnt        (cnt),
        .lo_q       (lo_q),
        .hi_q       (hi_q),
        .adv        (adv),
        .fall_stb   (fall_stb),
        .rise_stb   (rise_stb),
        .mid_lo_stb (mid_lo_stb),
        .mid_hi_stb (mid_hi_stb)
    );
endmodule

// File: rtl/sclgen_chk.sv
// sclgen_chk: port-level properties of the SCL generator, bound to the top module.
module sclgen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic run,
    input logic scl_out,
    input logic fall_stb,
    input logic rise_stb,
    input logic mid_lo_stb,
    input logic mid_hi_stb
);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb, mid_lo_stb, mid_hi_stb}));

    // R5
    low_strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb || mid_lo_stb) |-> !scl_out);

    // R5
    high_strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb || mid_hi_stb) |-> scl_out);

    // R7
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> scl_out);

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run) |=> $stable(scl_out));

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(fall_stb || rise_stb || mid_lo_stb || mid_hi_stb));
endmodule

bind i2c_scl_phase_gen sclgen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .run        (run),
    .scl_out    (scl_out),
    .fall_stb   (fall_stb),
    .rise_stb   (rise_stb),
    .mid_lo_stb (mid_lo_stb),
    .mid_hi_stb (mid_hi_stb)
);

// File: tb/tb_i2c_scl_phase_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_phase_gen;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          run = 1'b0;
    logic [DW-1:0] div_lo = '0;
    logic [DW-1:0] div_hi = '0;
    logic          slave_hold = 1'b0;
    logic          scl_in;
    logic          scl_out, fall_stb, rise_stb, mid_lo_stb, mid_hi_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Open-drain line: low when the master drives low or the slave stretches.
    assign scl_in = scl_out & ~slave_hold;

    i2c_scl_phase_gen #(.DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run),
        .div_lo(div_lo), .div_hi(div_hi), .scl_in(scl_in),
        .scl_out(scl_out), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .mid_lo_stb(mid_lo_stb), .mid_hi_stb(mid_hi_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for the first sample of a new low phase.
    task automatic wait_fall();
        bit prev;
        int guard;
        prev = scl_out;
        guard = 0;
        @(negedge clk);
        while (!(prev && !scl_out) && guard < 5000) begin
            prev = scl_out;
            guard++;
            @(negedge clk);
        end
    endtask

    // Count samples at level lvl starting with the current one; record strobe positions.
    task automatic count_phase(input bit lvl, output int n, output int edge_pos,
                               output int mid_pos, output int n_edge, output int n_mid,
                               output int n_other);
        n = 0; edge_pos = -1; mid_pos = -1; n_edge = 0; n_mid = 0; n_other = 0;
        while (scl_out == lvl && n < 5000) begin
            if (!lvl) begin
                if (fall_stb)   begin n_edge++; edge_pos = n; end
                if (mid_lo_stb) begin n_mid++;  mid_pos = n;  end
                if (rise_stb || mid_hi_stb) n_other++;
            end else begin
                if (rise_stb)   begin n_edge++; edge_pos = n; end
                if (mid_hi_stb) begin n_mid++;  mid_pos = n;  end
                if (fall_stb || mid_lo_stb) n_other++;
            end
            n++;
            @(negedge clk);
        end
    endtask

    // R7 / R8: reset state, then the start-up from the released state.
    task automatic t_reset();
        rst_n = 1'b0; en = 1'b1; run = 1'b1;
        repeat (3) @(negedge clk);
        check(scl_out == 1'b1, "R7 reset scl", scl_out, 1);
        check({fall_stb, rise_stb, mid_lo_stb, mid_hi_stb} == 4'b0, "R7 reset strobes",
              {fall_stb, rise_stb, mid_lo_stb, mid_hi_stb}, 0);
        run = 1'b0;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(scl_out == 1'b1, "R8 idle with run low", scl_out, 1);
        run = 1'b1;
        @(negedge clk);
        check(scl_out == 1'b0 && fall_stb, "R8 start one cycle after run", scl_out, 0);
    endtask

    // R1 R2 R5: one full period with given fields.
    task automatic t_period(input int dl, input int dh);
        int n, ep, mp, ne, nm, no;
        div_lo = DW'(dl); div_hi = DW'(dh);
        wait_fall();
        count_phase(1'b0, n, ep, mp, ne, nm, no);
        check(n == 8 * (dl + 1), "R1 low length", n, 8 * (dl + 1));
        check(ne == 1 && ep == 0, "R5 fall strobe pos", ep, 0);
        check(nm == 1 && mp == 4 * (dl + 1), "R5 mid_lo pos", mp, 4 * (dl + 1));
        check(no == 0, "R5 no high strobes in low", no, 0);
        count_phase(1'b1, n, ep, mp, ne, nm, no);
        check(n == 8 * (dh + 1), "R2 high length", n, 8 * (dh + 1));
        check(ne == 1 && ep == 0, "R5 rise strobe pos", ep, 0);
        check(nm == 1 && mp == 4 * (dh + 1), "R5 mid_hi pos", mp, 4 * (dh + 1));
        check(no == 0, "R5 no low strobes in high", no, 0);
    endtask

    // R3: fields changed in a low phase apply only from the next low phase.
    task automatic t_change();
        int n, ep, mp, ne, nm, no;
        div_lo = 4'd1; div_hi = 4'd1;
        wait_fall();
        wait_fall();
        div_lo = 4'd3; div_hi = 4'd0;
        count_phase(1'b0, n, ep, mp, ne, nm, no);
        check(n == 16, "R3 current low keeps old field", n, 16);
        count_phase(1'b1, n, ep, mp, ne, nm, no);
        check(n == 16, "R3 following high keeps old field", n, 16);
        count_phase(1'b0, n, ep, mp, ne, nm, no);
        check(n == 32, "R3 next low uses new field", n, 32);
        count_phase(1'b1, n, ep, mp, ne, nm, no);
        check(n == 8, "R3 next high uses new field", n, 8);
    endtask

    // R4: slave stretches; line released in high-phase cycle 20.
    task automatic t_stretch();
        int n, ep, mp, ne, nm, no;
        bit stayed;
        div_lo = 4'd1; div_hi = 4'd1;
        wait_fall();
        slave_hold = 1'b1;
        while (!scl_out) @(negedge clk);
        stayed = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!scl_out) stayed = 1'b0;
        end
        slave_hold = 1'b0;
        count_phase(1'b1, n, ep, mp, ne, nm, no);
        check(stayed, "R4 scl_out held high while stretched", stayed, 1);
        check(20 + n == 36, "R4 stretched high length", 20 + n, 36);
        count_phase(1'b0, n, ep, mp, ne, nm, no);
        check(n == 16, "R4 low after stretch", n, 16);
    endtask

    // R6: run low for 10 cycles inside a low phase.
    task automatic t_hold();
        int n, ep, mp, ne, nm, no;
        bit quiet;
        div_lo = 4'd1; div_hi = 4'd1;
        wait_fall();
        run = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (scl_out || fall_stb || rise_stb || mid_lo_stb || mid_hi_stb) quiet = 1'b0;
        end
        run = 1'b1;
        count_phase(1'b0, n, ep, mp, ne, nm, no);
        check(quiet, "R6 frozen and quiet while held", quiet, 1);
        check(10 + n == 26, "R6 held low length", 10 + n, 26);
    endtask

    // R7: disable in mid low phase, then re-enable with a full-length phase.
    task automatic t_disable();
        int n, ep, mp, ne, nm, no;
        div_lo = 4'd2; div_hi = 4'd1;
        wait_fall();
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(scl_out == 1'b1, "R7 disable releases scl", scl_out, 1);
        check({fall_stb, rise_stb, mid_lo_stb, mid_hi_stb} == 4'b0, "R7 disable strobes",
              {fall_stb, rise_stb, mid_lo_stb, mid_hi_stb}, 0);
        en = 1'b1;
        @(negedge clk);
        count_phase(1'b0, n, ep, mp, ne, nm, no);
        check(n == 24, "R7 full low after re-enable", n, 24);
        check(ne == 1 && ep == 0, "R8 fall strobe after re-enable", ep, 0);
    endtask

    initial begin
        t_reset();
        t_period(0, 0);
        t_period(2, 3);
        t_period(15, 0);
        t_period(0, 15);
        t_change();
        t_stretch();
        t_hold();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule